// File: doc/BRIEF.md
# Synchronous FIFO with Rewind and Soft Clear

`fifo_rt` is a single-clock FIFO with a 36-bit word. Words go in on a write strobe and come out through a registered read port. Four status flags are derived from the stored word count: full, empty, almost full and almost empty. The two "almost" thresholds are applied on input pins. They are captured only while the hard reset is held, so the rest of the system can leave those pins free afterwards.

A single active-low control pin has two uses, chosen by a mode input:

- With the mode input low, the pin performs a soft clear. This empties the FIFO but keeps the captured thresholds.
- With the mode input high, the pin performs a rewind. Only the read pointer returns to the first location, so the words written since the last clear can be read again.

The hard reset has priority over the shared pin. The shared pin has priority over normal reads and writes. A typical use is a packet buffer: a consumer that detects a corrupt transfer rewinds and replays, and a producer that abandons a packet soft-clears.

Top module: `fifo_rt`

## Requirements
- R1: While `mrst_n` is low at a rising clock edge, the FIFO empties and `rd_data` becomes all zeroes. `ae_off_in` and `af_off_in` are captured at every such edge, so the values at the last low edge are kept. The user holds `mrst_n` low for at least four edges.
- R2: Words are read back in write order. A read happens on an edge with `rd_en` high and `empty` low. After that edge, `rd_data` holds the oldest stored word.
- R3: A write attempted while `full` is high is dropped. The count and the stored words do not change.
- R4: A read attempted while `empty` is high is dropped. `rd_data` keeps its previous value.
- R5: A read and a write on the same edge are both performed when neither is blocked, and the count is unchanged. A write on an edge where the FIFO is empty proceeds even though the read is dropped. A read on an edge where the FIFO is full proceeds even though the write is dropped.
- R6: An edge with `prst_rt_n` low, `rt_mode` low and `mrst_n` high empties the FIFO and zeroes `rd_data`. The captured thresholds are kept, whatever `ae_off_in` and `af_off_in` show.
- R7: An edge with `prst_rt_n` low, `rt_mode` high and `mrst_n` high returns the read pointer to the first location. The write pointer and `rd_data` are kept. After that edge the count equals the number of words written since the last clear, and the flags reflect it. Subsequent reads replay the words from the first one.
- R8: `almost_empty` is high exactly when the count is at or below the captured almost-empty threshold.
- R9: `almost_full` is high exactly when the free space (DEPTH minus count) is at or below the captured almost-full threshold.
- R10: `empty` is high exactly at count 0, and `full` is high exactly at count DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mrst_n | input | 1 | Hard reset, active low, synchronous; captures thresholds |
| prst_rt_n | input | 1 | Shared soft-clear / rewind strobe, active low |
| rt_mode | input | 1 | 0: strobe soft-clears, 1: strobe rewinds |
| ae_off_in | input | AW+1 | Almost-empty threshold, captured during hard reset |
| af_off_in | input | AW+1 | Almost-full threshold, captured during hard reset |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Registered read word |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Free space at or below threshold |
| almost_empty | output | 1 | Count at or below threshold |

## Verification
The pointers are internal, but their difference drives all four flags. A pointer that slips therefore shows up on a flag in the cycle after the faulty edge, and as a misordered word on the next read.

A threshold register that is wrongly overwritten by a soft clear only shows when the count crosses that threshold. For this reason the bench changes the threshold pins before the soft clear and then parks the count between the old and new values.

A rewind that also moves the write pointer, or that corrupts `rd_data`, is caught on the edge after the strobe, and again by the replayed words.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int W  = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_rt_n,
  input  logic          rt_mode,
  input  logic [AW:0]   ae_off_in,
  input  logic [AW:0]   af_off_in,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, cnt, ae_cfg, af_cfg;

  wire soft_clr = mrst_n && !prst_rt_n && !rt_mode;
  wire rewind   = mrst_n && !prst_rt_n &&  rt_mode;
  wire run      = mrst_n &&  prst_rt_n;
  wire do_wr    = run && wr_en && !full;
  wire do_rd    = run && rd_en && !empty;

  assign cnt          = wp - rp;
  assign empty        = cnt == '0;
  assign full         = cnt == DEPTH_V;
  assign almost_empty = cnt <= ae_cfg;
  assign almost_full  = (DEPTH_V - cnt) <= af_cfg;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wp      <= '0;
      rp      <= '0;
      rd_data <= '0;
      ae_cfg  <= ae_off_in;
      af_cfg  <= af_off_in;
    end else if (soft_clr) begin
      wp      <= '0;
      rp      <= '0;
      rd_data <= '0;
    end else if (rewind) begin
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;

endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int W  = 36,
  parameter int AW = 4
) (
  input logic         clk,
  input logic         mrst_n,
  input logic         prst_rt_n,
  input logic         rt_mode,
  input logic         wr_en,
  input logic         rd_en,
  input logic         full,
  input logic         empty,
  input logic [W-1:0] rd_data,
  input logic [AW:0]  wp,
  input logic [AW:0]  rp,
  input logic [AW:0]  ae_cfg,
  input logic [AW:0]  af_cfg
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_rt_n && full && wr_en && !rd_en) |=> (full && $stable(wp)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_rt_n && empty && rd_en) |=> ($stable(rp) && $stable(rd_data)));

  assert_same_edge_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_rt_n && wr_en && rd_en && !full && !empty) |=> $stable(wp - rp));

  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_rt_n && !rt_mode) |=> (empty && rd_data == '0 && $stable(ae_cfg) && $stable(af_cfg)));

  assert_rewind_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (!prst_rt_n && rt_mode) |=> (rp == '0 && $stable(wp) && $stable(rd_data)));

  assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    !(full && empty));
endmodule

bind fifo_rt fifo_rt_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_rt_n(prst_rt_n), .rt_mode(rt_mode),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty), .rd_data(rd_data),
  .wp(wp), .rp(rp), .ae_cfg(ae_cfg), .af_cfg(af_cfg)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
  localparam int W = 36;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic mrst_n, prst_rt_n, rt_mode, wr_en, rd_en;
  logic [AW:0] ae_off_in, af_off_in;
  logic [W-1:0] wr_data, rd_data;
  logic full, empty, almost_full, almost_empty;
  int checks = 0, fails = 0;
  logic [AW:0] ae_exp, af_exp;

  always #2 clk = ~clk;

  fifo_rt #(.W(W), .AW(AW)) dut (
    .clk(clk), .mrst_n(mrst_n), .prst_rt_n(prst_rt_n), .rt_mode(rt_mode),
    .ae_off_in(ae_off_in), .af_off_in(af_off_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty));

  function automatic logic [W-1:0] pat(input logic [7:0] b);
    return {b[3:0], b, b, b, b};
  endfunction

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] d;
    logic [4:0] cnt;
    logic       chk;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // ae/af thresholds 2/2, depth 8
  localparam vec_t VECS [23] = '{
    '{1'b1,1'b0,8'h11,5'd1,1'b0,8'h00,4'd2},   // R2 fill
    '{1'b1,1'b0,8'h22,5'd2,1'b0,8'h00,4'd8},   // R8 ae at threshold
    '{1'b1,1'b0,8'h33,5'd3,1'b0,8'h00,4'd8},   // R8 ae just above
    '{1'b0,1'b1,8'h00,5'd2,1'b1,8'h11,4'd2},   // R2 oldest first
    '{1'b1,1'b1,8'h44,5'd2,1'b1,8'h22,4'd5},   // R5 both on one edge
    '{1'b1,1'b0,8'h55,5'd3,1'b0,8'h00,4'd2},
    '{1'b1,1'b0,8'h66,5'd4,1'b0,8'h00,4'd2},
    '{1'b1,1'b0,8'h77,5'd5,1'b0,8'h00,4'd9},   // R9 free 3
    '{1'b1,1'b0,8'h88,5'd6,1'b0,8'h00,4'd9},   // R9 free 2
    '{1'b1,1'b0,8'h99,5'd7,1'b0,8'h00,4'd9},
    '{1'b1,1'b0,8'hAA,5'd8,1'b0,8'h00,4'd10},  // R10 full
    '{1'b1,1'b0,8'hBB,5'd8,1'b0,8'h00,4'd3},   // R3 dropped
    '{1'b1,1'b1,8'hCC,5'd7,1'b1,8'h33,4'd5},   // R5 read on full
    '{1'b0,1'b1,8'h00,5'd6,1'b1,8'h44,4'd2},
    '{1'b0,1'b1,8'h00,5'd5,1'b1,8'h55,4'd2},
    '{1'b0,1'b1,8'h00,5'd4,1'b1,8'h66,4'd2},
    '{1'b0,1'b1,8'h00,5'd3,1'b1,8'h77,4'd2},
    '{1'b0,1'b1,8'h00,5'd2,1'b1,8'h88,4'd2},
    '{1'b0,1'b1,8'h00,5'd1,1'b1,8'h99,4'd2},
    '{1'b0,1'b1,8'h00,5'd0,1'b1,8'hAA,4'd3},   // R3 BB never stored
    '{1'b0,1'b1,8'h00,5'd0,1'b1,8'hAA,4'd4},   // R4 empty read dropped
    '{1'b1,1'b1,8'hDD,5'd1,1'b1,8'hAA,4'd5},   // R5 write on empty
    '{1'b0,1'b1,8'h00,5'd0,1'b1,8'hDD,4'd2}
  };

  task automatic check_cnt(input int c, input string tag);
    logic [3:0] got, exp;
    got = {empty, full, almost_empty, almost_full};
    exp = {c == 0, c == DEPTH, c <= int'(ae_exp), (DEPTH - c) <= int'(af_exp)};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s flags e/f/ae/af got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic check_rd(input logic [W-1:0] e, input string tag);
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s rd_data got %h exp %h", tag, rd_data, e);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = pat(d);
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic strobe(input logic mode);
    @(negedge clk);
    prst_rt_n = 0; rt_mode = mode;
    @(posedge clk); #1;
    prst_rt_n = 1;
  endtask

  task automatic hard_reset(input logic [AW:0] ae, input logic [AW:0] af);
    @(negedge clk);
    mrst_n = 0; ae_off_in = ae; af_off_in = af;
    repeat (4) @(posedge clk);
    #1; mrst_n = 1;
    ae_exp = ae; af_exp = af;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mrst_n = 0; prst_rt_n = 1; rt_mode = 0; wr_en = 0; rd_en = 0;
    wr_data = '0; ae_off_in = 2; af_off_in = 2;
    hard_reset(5'd2, 5'd2);
    check_cnt(0, "R1 reset flags");
    check_rd('0, "R1 reset data");

    foreach (VECS[i]) begin
      step(VECS[i].wr, VECS[i].rd, VECS[i].d);
      check_cnt(int'(VECS[i].cnt), $sformatf("R%0d vec %0d", VECS[i].req, i));
      if (VECS[i].chk) check_rd(pat(VECS[i].exp), $sformatf("R%0d vec %0d", VECS[i].req, i));
    end

    // R6: soft clear keeps thresholds although the pins move
    step(1, 0, 8'hE1); step(1, 0, 8'hE2); step(0, 1, 8'h00);
    ae_off_in = 7; af_off_in = 7;
    strobe(0);
    check_cnt(0, "R6 cleared");
    check_rd('0, "R6 data zero");
    step(1, 0, 8'hF1); step(1, 0, 8'hF2); step(1, 0, 8'hF3);
    check_cnt(3, "R6 thresholds kept");

    // R7: rewind replays from the first word
    step(0, 1, 8'h00); check_rd(pat(8'hF1), "R7 pre");
    step(0, 1, 8'h00); check_rd(pat(8'hF2), "R7 pre");
    check_cnt(1, "R7 before rewind");
    strobe(1);
    check_cnt(3, "R7 count after rewind");
    check_rd(pat(8'hF2), "R7 data held");
    step(0, 1, 8'h00); check_rd(pat(8'hF1), "R7 replay");
    step(0, 1, 8'h00); check_rd(pat(8'hF2), "R7 replay");
    step(0, 1, 8'h00); check_rd(pat(8'hF3), "R7 replay");
    check_cnt(0, "R7 drained");

    // R1 recapture; R8/R9/R10 at new thresholds 5/0
    step(1, 0, 8'h5A);
    hard_reset(5'd5, 5'd0);
    check_cnt(0, "R1 re-reset flags");
    check_rd('0, "R1 re-reset data");
    for (int k = 1; k <= DEPTH; k++) begin
      step(1, 0, 8'(k));
      check_cnt(k, $sformatf("R8 R9 R10 fill %0d", k));
    end
    for (int k = 1; k <= 2; k++) begin
      step(0, 1, 8'h00);
      check_rd(pat(8'(k)), "R2 after recapture");
    end
    finish_run();
  end
endmodule